// File: doc/BRIEF.md
# Multi-Shot Ping-Pong Acquisition Sequencer

The sequencer captures a configurable number of shots from a sample stream. Each shot is written into one of two on-chip banks, and the banks alternate from shot to shot. A shot holds a window of samples taken before the trigger, the trigger sample itself, a window taken after it, and a 64-bit time value captured at the trigger instant. The time value is stored as two words, low half first.

A finished bank is handed to a transfer engine. The engine reads the bank out in time order onto a simple address/data/valid/ready write port. Meanwhile the recorder fills the other bank. Shots are packed back to back in the external address space, starting from address zero. Control logic reports the number of shots still to be captured, pulses an interrupt at each trigger, and pulses a final interrupt once every word has been accepted. It refuses a start whose shot would not fit in a bank. If a bank is still waiting to be drained when it is needed again, the sequencer raises a sticky overrun flag and waits.

Top module: `acq_multishot`

## Requirements
- R1: After reset, `busy`, `mem_valid`, `trig_irq`, `done_irq`, `start_err` and `overrun` are 0 and `shots_left` is 0.
- R2: A start pulse in the idle state is accepted only when `cfg_shots` is nonzero and `cfg_pre + cfg_post + 3 <= DEPTH`. Otherwise `start_err` is 1 for exactly the cycle after the pulse and `busy` stays 0.
- R3: On an accepted start, from the next cycle on, `busy` is 1, `shots_left` equals `cfg_shots` and `overrun` is 0, and external addressing restarts at 0.
- R4: Shots alternate between bank 0 (even shot index) and bank 1 (odd shot index). A bank is handed to the transfer engine only when it is not already waiting to be drained.
- R5: Each shot produces exactly `cfg_pre + cfg_post + 3` accepted output words. Accepted addresses are consecutive from 0 across all shots of an acquisition.
- R6: Within a shot the output order is as follows: the last `cfg_pre` samples before the trigger (oldest first), the trigger sample, the `cfg_post` following samples, then bits 31:0 and then bits 63:32 of `time_now` as sampled on the trigger sample's cycle.
- R7: `smp_trig` is ignored while the pre-trigger window is still filling, and on any cycle where `smp_valid` is 0.
- R8: `trig_irq` is a one-cycle pulse for each trigger sample, so there are exactly `cfg_shots` pulses per acquisition.
- R9: `shots_left` decreases by one when each shot's time value has been stored, and reaches 0 after the last shot.
- R10: `done_irq` pulses once per acquisition, after the last output word has been accepted. `busy` is 0 in that same cycle.
- R11: When the next bank to record is still waiting to be drained, `overrun` becomes 1 and stays 1 until the next accepted start. Recording waits, and samples offered meanwhile are dropped.
- R12: While `mem_valid` is 1 and `mem_ready` is 0, the next cycle keeps `mem_valid` at 1 with the same `mem_addr` and `mem_data`.
- R13: A zero pre-trigger window or a zero post-trigger window is accepted and handled with the same word layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_start | input | 1 | Start request pulse |
| cfg_pre | input | $clog2(DEPTH) | Pre-trigger window length, sampled at start |
| cfg_post | input | $clog2(DEPTH) | Post-trigger window length, sampled at start |
| cfg_shots | input | SHOT_W | Number of shots, sampled at start |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DW | Sample word |
| smp_trig | input | 1 | Trigger qualifier for the current sample |
| time_now | input | 2*DW | Free-running time value |
| mem_addr | output | EXT_AW | External word address |
| mem_data | output | DW | External write data |
| mem_valid | output | 1 | Write request |
| mem_ready | input | 1 | Write accepted when high with `mem_valid` |
| busy | output | 1 | Acquisition in progress |
| start_err | output | 1 | Start rejected pulse |
| shots_left | output | SHOT_W | Shots still to be captured |
| trig_irq | output | 1 | Per-trigger interrupt pulse |
| done_irq | output | 1 | End-of-acquisition interrupt pulse |
| overrun | output | 1 | Sticky bank-reuse overrun flag |

## Verification
The assertions assume that the configuration inputs only matter on the cycle a start is accepted, and that `mem_ready` may take any value on any cycle. They also assume that a bank's contents do not change while the engine presents a word from it. This holds because the recorder never writes to a bank that is waiting to be drained. The bench drives `mem_ready` at random except in the overrun scenario. Before each shot from the third onward, it waits until the shot two places earlier has been fully accepted. This keeps the normal runs free of overrun, so the one deliberate overrun, with `mem_ready` held low, is the only case where recording waits.

// File: rtl/acq_ms_pkg.sv
package acq_ms_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_PRE,
    ST_WAIT,
    ST_POST,
    ST_TAG_LO,
    ST_TAG_HI,
    ST_DRAIN
  } rec_state_e;

endpackage

// File: rtl/acq_ms_buffer.sv
module acq_ms_buffer #(
  parameter int DW    = 32,
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int NBANK = 2;

  logic [DW-1:0] bank_rd [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    logic          we_b;

    assign we_b = wr_en && (wr_bank == 1'(b));

    always_ff @(posedge clk) begin
      if (we_b) begin
        mem[wr_addr] <= wr_data;
      end
    end

    assign bank_rd[b] = mem[rd_addr];
  end

  assign rd_data = rd_bank ? bank_rd[1] : bank_rd[0];

endmodule

// File: rtl/acq_ms_recorder.sv
module acq_ms_recorder
  import acq_ms_pkg::*;
#(
  parameter int DW     = 32,
  parameter int DEPTH  = 2048,
  parameter int AW     = 11,
  parameter int SHOT_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   cfg_pre,
  input  logic [AW-1:0]   cfg_post,
  input  logic [SHOT_W-1:0] cfg_shots,
  input  logic            smp_valid,
  input  logic [DW-1:0]   smp_data,
  input  logic            smp_trig,
  input  logic [2*DW-1:0] time_now,
  input  logic [1:0]      bank_pending,
  output logic            wr_en,
  output logic            wr_bank,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            shot_done,
  output logic            shot_bank,
  output logic [AW-1:0]   shot_oldest,
  output logic            acq_clr,
  output logic [AW-1:0]   pre_len,
  output logic [AW:0]     words_len,
  output logic            busy,
  output logic            start_err,
  output logic [SHOT_W-1:0] shots_left,
  output logic            trig_irq,
  output logic            done_irq,
  output logic            overrun
);

  localparam int CW = AW + 1;
  localparam int SW = AW + 2;

  rec_state_e        state_q, state_d;
  logic [AW-1:0]     pre_q, post_q;
  logic [CW-1:0]     words_q;
  logic [SHOT_W-1:0] shots_q, shots_d;
  logic              bank_q, bank_d;
  logic [AW-1:0]     cnt_q, cnt_d;
  logic [AW-1:0]     wptr_q, wptr_d;
  logic [AW-1:0]     oldest_q;
  logic [2*DW-1:0]   tag_q;
  logic              ovr_q, ovr_d;
  logic              err_q, err_d;
  logic              tirq_q, tirq_d;
  logic              dirq_q, dirq_d;
  logic              cfg_load, trig_hit;

  logic [SW-1:0]     need_words;
  logic              cfg_ok;
  logic [AW-1:0]     pre_last, post_last, wptr_nxt;

  assign need_words = SW'(cfg_pre) + SW'(cfg_post) + SW'(3);
  assign cfg_ok     = (cfg_shots != '0) && (need_words <= SW'(DEPTH));
  assign pre_last   = pre_q - AW'(1);
  assign post_last  = post_q - AW'(1);
  assign wptr_nxt   = (wptr_q == pre_last) ? '0 : wptr_q + AW'(1);

  always_comb begin
    state_d   = state_q;
    shots_d   = shots_q;
    bank_d    = bank_q;
    cnt_d     = cnt_q;
    wptr_d    = wptr_q;
    ovr_d     = ovr_q;
    err_d     = 1'b0;
    tirq_d    = 1'b0;
    dirq_d    = 1'b0;
    cfg_load  = 1'b0;
    trig_hit  = 1'b0;
    acq_clr   = 1'b0;
    shot_done = 1'b0;
    wr_en     = 1'b0;
    wr_addr   = '0;
    wr_data   = smp_data;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (cfg_ok) begin
            cfg_load = 1'b1;
            acq_clr  = 1'b1;
            shots_d  = cfg_shots;
            bank_d   = 1'b0;
            ovr_d    = 1'b0;
            state_d  = ST_ARM;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_ARM: begin
        if (bank_pending[bank_q]) begin
          ovr_d = 1'b1;
        end else begin
          cnt_d   = '0;
          wptr_d  = '0;
          state_d = (pre_q == '0) ? ST_WAIT : ST_PRE;
        end
      end
      ST_PRE: begin
        if (smp_valid) begin
          wr_en   = 1'b1;
          wr_addr = wptr_q;
          wptr_d  = wptr_nxt;
          cnt_d   = cnt_q + AW'(1);
          if (cnt_q == pre_last) begin
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (smp_valid) begin
          if (smp_trig) begin
            wr_en    = 1'b1;
            wr_addr  = pre_q;
            trig_hit = 1'b1;
            tirq_d   = 1'b1;
            cnt_d    = '0;
            state_d  = (post_q == '0) ? ST_TAG_LO : ST_POST;
          end else if (pre_q != '0) begin
            wr_en   = 1'b1;
            wr_addr = wptr_q;
            wptr_d  = wptr_nxt;
          end
        end
      end
      ST_POST: begin
        if (smp_valid) begin
          wr_en   = 1'b1;
          wr_addr = pre_q + cnt_q + AW'(1);
          cnt_d   = cnt_q + AW'(1);
          if (cnt_q == post_last) begin
            state_d = ST_TAG_LO;
          end
        end
      end
      ST_TAG_LO: begin
        wr_en   = 1'b1;
        wr_addr = pre_q + post_q + AW'(1);
        wr_data = tag_q[DW-1:0];
        state_d = ST_TAG_HI;
      end
      ST_TAG_HI: begin
        wr_en     = 1'b1;
        wr_addr   = pre_q + post_q + AW'(2);
        wr_data   = tag_q[2*DW-1:DW];
        shot_done = 1'b1;
        shots_d   = shots_q - SHOT_W'(1);
        bank_d    = ~bank_q;
        state_d   = (shots_q == SHOT_W'(1)) ? ST_DRAIN : ST_ARM;
      end
      ST_DRAIN: begin
        if (bank_pending == 2'b00) begin
          dirq_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pre_q    <= '0;
      post_q   <= '0;
      words_q  <= '0;
      shots_q  <= '0;
      bank_q   <= 1'b0;
      cnt_q    <= '0;
      wptr_q   <= '0;
      oldest_q <= '0;
      tag_q    <= '0;
      ovr_q    <= 1'b0;
      err_q    <= 1'b0;
      tirq_q   <= 1'b0;
      dirq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      shots_q <= shots_d;
      bank_q  <= bank_d;
      cnt_q   <= cnt_d;
      wptr_q  <= wptr_d;
      ovr_q   <= ovr_d;
      err_q   <= err_d;
      tirq_q  <= tirq_d;
      dirq_q  <= dirq_d;
      if (cfg_load) begin
        pre_q   <= cfg_pre;
        post_q  <= cfg_post;
        words_q <= CW'(need_words);
      end
      if (trig_hit) begin
        tag_q    <= time_now;
        oldest_q <= wptr_q;
      end
    end
  end

  assign wr_bank     = bank_q;
  assign shot_bank   = bank_q;
  assign shot_oldest = oldest_q;
  assign pre_len     = pre_q;
  assign words_len   = words_q;
  assign busy        = (state_q != ST_IDLE);
  assign start_err   = err_q;
  assign shots_left  = shots_q;
  assign trig_irq    = tirq_q;
  assign done_irq    = dirq_q;
  assign overrun     = ovr_q;

  assert_wr_in_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_addr} < words_q));

  assert_err_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_err |-> !busy);

  assert_shots_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (shots_left <= $past(shots_left)));

  assert_irq_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig_irq && done_irq));

  assert_overrun_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARM && bank_pending[bank_q]) |=> overrun);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (!busy && bank_pending == 2'b00));

endmodule

// File: rtl/acq_ms_xfer.sv
module acq_ms_xfer #(
  parameter int AW     = 11,
  parameter int DW     = 32,
  parameter int EXT_AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shot_done,
  input  logic              shot_bank,
  input  logic [AW-1:0]     shot_oldest,
  input  logic [AW-1:0]     pre_len,
  input  logic [AW:0]       words_len,
  input  logic [DW-1:0]     rd_data,
  input  logic              mem_ready,
  output logic [1:0]        pending,
  output logic              rd_bank,
  output logic [AW-1:0]     rd_addr,
  output logic [EXT_AW-1:0] mem_addr,
  output logic [DW-1:0]     mem_data,
  output logic              mem_valid
);

  localparam int CW    = AW + 1;
  localparam int NBANK = 2;

  logic              xbuf_q, xbuf_d;
  logic [AW-1:0]     k_q, k_d;
  logic [EXT_AW-1:0] base_q, base_d;
  logic [AW-1:0]     old_w [NBANK];
  logic              fire, last;
  logic [CW-1:0]     ring_idx;

  assign mem_valid = pending[xbuf_q];
  assign fire      = mem_valid && mem_ready;
  assign last      = ({1'b0, k_q} == (words_len - CW'(1)));

  for (genvar b = 0; b < NBANK; b++) begin : g_slot
    logic          pend_b;
    logic [AW-1:0] old_b;
    logic          set_b, drop_b;

    assign set_b  = shot_done && (shot_bank == 1'(b));
    assign drop_b = fire && last && (xbuf_q == 1'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_b <= 1'b0;
        old_b  <= '0;
      end else begin
        if (clr) begin
          pend_b <= 1'b0;
        end else if (set_b) begin
          pend_b <= 1'b1;
        end else if (drop_b) begin
          pend_b <= 1'b0;
        end
        if (set_b) begin
          old_b <= shot_oldest;
        end
      end
    end

    assign pending[b] = pend_b;
    assign old_w[b]   = old_b;

    assert_no_double_hand_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set_b |-> !pend_b);
  end

  always_comb begin
    ring_idx = CW'(old_w[xbuf_q]) + CW'(k_q);
    if (ring_idx >= CW'(pre_len)) begin
      ring_idx = ring_idx - CW'(pre_len);
    end
    if (k_q < pre_len) begin
      rd_addr = ring_idx[AW-1:0];
    end else begin
      rd_addr = k_q;
    end
  end

  always_comb begin
    xbuf_d = xbuf_q;
    k_d    = k_q;
    base_d = base_q;
    if (clr) begin
      xbuf_d = 1'b0;
      k_d    = '0;
      base_d = '0;
    end else if (fire) begin
      if (last) begin
        k_d    = '0;
        xbuf_d = ~xbuf_q;
        base_d = base_q + EXT_AW'(words_len);
      end else begin
        k_d = k_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xbuf_q <= 1'b0;
      k_q    <= '0;
      base_q <= '0;
    end else begin
      xbuf_q <= xbuf_d;
      k_q    <= k_d;
      base_q <= base_d;
    end
  end

  assign rd_bank  = xbuf_q;
  assign mem_addr = base_q + EXT_AW'(k_q);
  assign mem_data = rd_data;

  assert_hold_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  assert_addr_consec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (!mem_valid || mem_addr == $past(mem_addr) + EXT_AW'(1)));

endmodule

// File: rtl/acq_multishot.sv
module acq_multishot #(
  parameter int DW     = 32,
  parameter int DEPTH  = 2048,
  parameter int SHOT_W = 16,
  parameter int EXT_AW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acq_start,
  input  logic [$clog2(DEPTH)-1:0] cfg_pre,
  input  logic [$clog2(DEPTH)-1:0] cfg_post,
  input  logic [SHOT_W-1:0]        cfg_shots,
  input  logic                     smp_valid,
  input  logic [DW-1:0]            smp_data,
  input  logic                     smp_trig,
  input  logic [2*DW-1:0]          time_now,
  output logic [EXT_AW-1:0]        mem_addr,
  output logic [DW-1:0]            mem_data,
  output logic                     mem_valid,
  input  logic                     mem_ready,
  output logic                     busy,
  output logic                     start_err,
  output logic [SHOT_W-1:0]        shots_left,
  output logic                     trig_irq,
  output logic                     done_irq,
  output logic                     overrun
);

  localparam int AW = $clog2(DEPTH);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          wr_en, wr_bank;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          shot_done, shot_bank, acq_clr;
  logic [AW-1:0] shot_oldest, pre_len;
  logic [AW:0]   words_len;
  logic [1:0]    pending;
  logic          rd_bank;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  acq_ms_recorder #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .SHOT_W(SHOT_W)) i_rec (
    .clk(clk), .rst_n(rst_int_n), .start(acq_start),
    .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cfg_shots(cfg_shots),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_trig(smp_trig),
    .time_now(time_now), .bank_pending(pending),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
    .shot_done(shot_done), .shot_bank(shot_bank), .shot_oldest(shot_oldest),
    .acq_clr(acq_clr), .pre_len(pre_len), .words_len(words_len),
    .busy(busy), .start_err(start_err), .shots_left(shots_left),
    .trig_irq(trig_irq), .done_irq(done_irq), .overrun(overrun)
  );

  acq_ms_buffer #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) i_buf (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  acq_ms_xfer #(.AW(AW), .DW(DW), .EXT_AW(EXT_AW)) i_xfer (
    .clk(clk), .rst_n(rst_int_n), .clr(acq_clr),
    .shot_done(shot_done), .shot_bank(shot_bank), .shot_oldest(shot_oldest),
    .pre_len(pre_len), .words_len(words_len), .rd_data(rd_data),
    .mem_ready(mem_ready), .pending(pending), .rd_bank(rd_bank),
    .rd_addr(rd_addr), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_valid(mem_valid)
  );

endmodule

// File: tb/test_acq_multishot.sv
module test_acq_multishot;

  localparam int DW     = 32;
  localparam int DEPTH  = 64;
  localparam int AW     = $clog2(DEPTH);
  localparam int SHOT_W = 8;
  localparam int EXT_AW = 16;
  localparam int MAXW   = 512;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              acq_start = 1'b0;
  logic [AW-1:0]     cfg_pre = '0, cfg_post = '0;
  logic [SHOT_W-1:0] cfg_shots = '0;
  logic              smp_valid = 1'b0, smp_trig = 1'b0;
  logic [DW-1:0]     smp_data = '0;
  logic [63:0]       ts_r = 64'h0123_4567_0000_0000;
  logic [EXT_AW-1:0] mem_addr;
  logic [DW-1:0]     mem_data;
  logic              mem_valid, mem_ready = 1'b0;
  logic              busy, start_err, trig_irq, done_irq, overrun;
  logic [SHOT_W-1:0] shots_left;

  int checks = 0, fails = 0;
  int rx_cnt = 0, trig_cnt = 0, done_cnt = 0, exp_total = 0;
  bit hold_ready = 1'b0, mon_on = 1'b0;
  int seq = 0;
  logic [DW-1:0] exp_mem [MAXW];
  logic [DW-1:0] got_mem [MAXW];
  logic [DW-1:0] hist [128];
  logic              prev_stall = 1'b0;
  logic [EXT_AW-1:0] prev_addr = '0;
  logic [DW-1:0]     prev_data = '0;

  always #10 clk = ~clk;

  always @(posedge clk) ts_r <= ts_r + 64'h0000_0001_0000_0003;

  acq_multishot #(.DW(DW), .DEPTH(DEPTH), .SHOT_W(SHOT_W), .EXT_AW(EXT_AW)) i_acq_multishot (
    .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .cfg_pre(cfg_pre),
    .cfg_post(cfg_post), .cfg_shots(cfg_shots), .smp_valid(smp_valid),
    .smp_data(smp_data), .smp_trig(smp_trig), .time_now(ts_r),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .busy(busy), .start_err(start_err),
    .shots_left(shots_left), .trig_irq(trig_irq), .done_irq(done_irq),
    .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    #2;
    mem_ready = hold_ready ? 1'b0 : (($urandom % 4) != 0);
  end

  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_stall) begin
        chk(mem_valid && mem_addr == prev_addr && mem_data == prev_data,
            "R12 hold under backpressure", {47'd0, mem_valid, mem_addr}, {48'd1, prev_addr});
      end
      prev_stall = mem_valid && !mem_ready;
      prev_addr  = mem_addr;
      prev_data  = mem_data;
      if (mem_valid && mem_ready) begin
        if (32'(mem_addr) != rx_cnt) begin
          chk(1'b0, "R5 consecutive address", 64'(mem_addr), 64'(rx_cnt));
        end
        if (int'(mem_addr) < MAXW) got_mem[mem_addr] = mem_data;
        rx_cnt++;
      end
      if (trig_irq) trig_cnt++;
      if (done_irq) begin
        done_cnt++;
        chk(!busy && rx_cnt == exp_total, "R10 done after last word, busy low",
            {31'd0, busy, 32'(rx_cnt)}, {32'd0, 32'(exp_total)});
      end
    end
  end

  task automatic drive(input logic v, input logic [DW-1:0] d, input logic t);
    @(posedge clk);
    #2;
    smp_valid = v;
    smp_data  = d;
    smp_trig  = t;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0, 1'b0);
  endtask

  function automatic logic [DW-1:0] next_data();
    seq++;
    return 32'hA000_0000 + 32'(seq);
  endfunction

  task automatic do_start(input int pre, input int post, input int shots);
    @(posedge clk);
    #2;
    cfg_pre = AW'(pre);
    cfg_post = AW'(post);
    cfg_shots = SHOT_W'(shots);
    acq_start = 1'b1;
    @(posedge clk);
    #2;
    acq_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_rx(input int n);
    while (rx_cnt < n) @(negedge clk);
  endtask

  task automatic run_shot(input int s, input int pre, input int post, input int words, input bit early);
    int n;
    logic [DW-1:0] td;
    logic [63:0] tsv;
    int base;
    if (s >= 2) wait_rx((s - 1) * words);
    idle(4);
    n = pre + int'($urandom % 4);
    for (int i = 0; i < n; i++) begin
      if (($urandom % 3) == 0) drive(1'b0, '0, 1'b0);
      hist[i] = next_data();
      drive(1'b1, hist[i], early && (i == 0) && (pre > 0));
    end
    drive(1'b0, '0, 1'b1);
    td = next_data();
    drive(1'b1, td, 1'b1);
    tsv = ts_r;
    base = s * words;
    for (int i = 0; i < pre; i++) exp_mem[base + i] = hist[n - pre + i];
    exp_mem[base + pre] = td;
    for (int i = 0; i < post; i++) begin
      if (($urandom % 3) == 0) drive(1'b0, '0, 1'b0);
      exp_mem[base + pre + 1 + i] = next_data();
      drive(1'b1, exp_mem[base + pre + 1 + i], 1'b0);
    end
    exp_mem[base + pre + post + 1] = tsv[31:0];
    exp_mem[base + pre + post + 2] = tsv[63:32];
    idle(4);
  endtask

  task automatic run_acq(input int pre, input int post, input int shots, input bit early, input bit ovr_case);
    int words;
    int t0, d0, bad;
    words = pre + post + 3;
    rx_cnt = 0;
    exp_total = shots * words;
    t0 = trig_cnt;
    d0 = done_cnt;
    do_start(pre, post, shots);
    chk(busy && shots_left == SHOT_W'(shots) && !overrun && !start_err, "R3 accepted start",
        {61'd0, busy, overrun, start_err}, 64'd4);
    for (int s = 0; s < shots; s++) begin
      run_shot(s, pre, post, words, early);
      chk(shots_left == SHOT_W'(shots - s - 1), "R9 shots_left after shot",
          64'(shots_left), 64'(shots - s - 1));
      if (ovr_case && s == 1) begin
        idle(3);
        chk(overrun == 1'b1, "R11 overrun on busy bank", 64'(overrun), 64'd1);
        for (int j = 0; j < 3; j++) drive(1'b1, 32'hDEAD_0000 + 32'(j), 1'b1);
        idle(2);
        chk(overrun == 1'b1 && rx_cnt == 0, "R11 overrun sticky, nothing moved",
            {31'd0, overrun, 32'(rx_cnt)}, {31'd0, 1'b1, 32'd0});
        hold_ready = 1'b0;
      end
    end
    while (done_cnt == d0) @(negedge clk);
    chk(rx_cnt == exp_total, "R5 word count", 64'(rx_cnt), 64'(exp_total));
    chk(trig_cnt - t0 == shots, "R8 trigger pulses", 64'(trig_cnt - t0), 64'(shots));
    idle(3);
    chk(done_cnt - d0 == 1 && !busy, "R10 single done pulse", 64'(done_cnt - d0), 64'd1);
    chk(overrun == ovr_case, "R11 overrun flag state", 64'(overrun), 64'(ovr_case));
    for (int s = 0; s < shots; s++) begin
      bad = 0;
      for (int i = 0; i < words; i++) begin
        if (got_mem[s * words + i] !== exp_mem[s * words + i]) bad++;
      end
      chk(bad == 0, $sformatf("R6 R4 shot %0d contents (R7 R13 pre=%0d post=%0d)", s, pre, post),
          64'(bad), 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!busy && !mem_valid && !trig_irq && !done_irq && !start_err && !overrun && shots_left == 0,
        "R1 reset state", {57'd0, busy, mem_valid, trig_irq, done_irq, start_err, overrun, |shots_left}, 64'd0);
    mon_on = 1'b1;

    do_start(40, 22, 2);
    chk(start_err && !busy, "R2 reject oversize shot", {62'd0, start_err, busy}, 64'd2);
    @(negedge clk);
    chk(!start_err && !busy, "R2 reject pulse one cycle", {62'd0, start_err, busy}, 64'd0);
    do_start(3, 3, 0);
    chk(start_err && !busy, "R2 reject zero shots", {62'd0, start_err, busy}, 64'd2);

    run_acq(30, 31, 2, 1'b1, 1'b0);
    run_acq(5, 7, 4, 1'b1, 1'b0);
    run_acq(0, 3, 3, 1'b0, 1'b0);
    run_acq(4, 0, 2, 1'b1, 1'b0);
    run_acq(1, 1, 5, 1'b1, 1'b0);
    hold_ready = 1'b1;
    run_acq(2, 2, 3, 1'b1, 1'b1);
    run_acq(3, 1, 2, 1'b0, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule